// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gating Controller

This block sits between a host register window and an enhanced-parallel-port peripheral. The host issues single accesses to an eight-offset window and to a separate upper window. Offset 3 starts a peripheral address cycle and offset 4 starts a peripheral data cycle. A cycle only starts when the stored control byte holds the exact bit pattern required for that direction. If the pattern does not match, a write is dropped and a read completes at once with all ones.

Each peripheral byte cycle raises the address strobe or the data strobe. The write qualifier is raised with the strobe on a write. The cycle then waits for the peripheral's wait handshake. If the handshake does not arrive within `TIMEOUT_CYC` clocks, a sticky timeout flag is set and the rest of the access is abandoned. The host sees that flag as bit 0 of the status register and clears it by writing a 1 to that bit.

The data port accepts byte, half-word and word accesses and moves the bytes least significant first. The plain data and control registers drive the peripheral lines directly. Each register raises a one-cycle update pulse only when its value really changes. A change of direction is announced one cycle before the control update.

Top module: `epp_gate_ctrl`

## Requirements
- R1: After reset the control register reads 0xCC, `dataBus` is 0xFF, `perDir` is 0, the timeout flag is 0 and no strobe or update pulse is active.
- R2: A write to offset 3 or 4 runs peripheral byte cycles only when (control & 0x2F) == 0x04. Otherwise it raises no strobe.
- R3: A read of offset 3 or 4 runs byte cycles only when (control & 0x2F) == 0x24. Otherwise it returns all ones at the access width: 0xFF for `hostSize` 0, 0xFFFF for `hostSize` 1 and 0xFFFFFFFF for `hostSize` 2 or 3, zero-extended to 32 bits.
- R4: `hostSize` 0, 1 and 2 move 1, 2 and 4 bytes through the data port, taking byte lane 0 first. The address port always moves exactly one byte, taken from `hostWdata[7:0]`.
- R5: A byte cycle whose strobe stays high for `TIMEOUT_CYC` clocks without `perWait` sets the timeout flag. A status read (offset 1) returns {`statusIn[7:1]`, flag}.
- R6: A status write with bit 0 set clears the timeout flag. A status write with bit 0 clear leaves the flag unchanged.
- R7: A multi-byte access stops at the first byte that times out and raises no further strobe. In a read, the bytes not collected read as 0xFF.
- R8: A write to offset 0 with a value different from `dataBus` updates `dataBus` and pulses `dataStb` for one cycle. A write of the value already held causes no pulse.
- R9: A write to offset 2 stores the value OR 0xC0. An unchanged value causes no pulse. A changed value pulses `ctrlStb`. If the direction bit (bit 5) changes, `perDir` takes the new bit and `dirStb` pulses exactly one cycle before `ctrlStb`.
- R10: Accesses with `hostHighWin` set read 0xFF and have no effect on any register or peripheral line.
- R11: A read of offset 0 returns `perDataIn`. A read of offset 2 returns the stored control byte. Reads of offsets 5, 6 and 7 return 0xFF.
- R12: At most one of `perAddrStb` and `perDataStb` is high at any time. `perWrite` is high only together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access request |
| hostReady | output | 1 | Controller idle; the request is taken on a clock where both are high |
| hostHighWin | input | 1 | Selects the inert upper window |
| hostOff | input | 3 | Register offset within the window |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | Access size for the data port: 0 byte, 1 half-word, 2 or 3 word |
| hostWdata | input | 32 | Write data |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdata | output | 32 | Read result, valid while `hostDone` is high |
| statusIn | input | 7 | External status lines for bits 7..1 |
| perAddrStb | output | 1 | Peripheral address strobe |
| perDataStb | output | 1 | Peripheral data strobe |
| perWrite | output | 1 | Write qualifier for the current byte cycle |
| perDataOut | output | 8 | Byte driven during a write cycle |
| perDataIn | input | 8 | Byte from the peripheral |
| perWait | input | 1 | Peripheral handshake |
| ctrlBus | output | 8 | Stored control byte |
| ctrlStb | output | 1 | Control update pulse |
| perDir | output | 1 | Data direction, 1 = peripheral to host |
| dirStb | output | 1 | Direction update pulse |
| dataBus | output | 8 | Stored data byte |
| dataStb | output | 1 | Data update pulse |

## Verification
A wrong stored control byte is visible the next time offset 3 or 4 is used. The cycle then either raises a strobe it should not, or returns the all-ones pattern when a transfer was due, within two clocks of the request. A wrong byte index or timeout count shows at the peripheral as a byte out of order or as a strobe held for a different number of clocks. It also shows in the read result as a misplaced lane or a missing 0xFF fill. A timeout flag stuck in the wrong state shows in bit 0 of the very next status read.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int HOST_W   = 32;
  localparam int HOST_B   = HOST_W / 8;
  localparam int IDX_W    = $clog2(HOST_B);
  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR   = 8'h04;
  localparam logic [7:0] GATE_RD   = 8'h24;
  localparam logic [7:0] CTRL_FIX  = 8'hC0;
  localparam logic [7:0] CTRL_RST  = 8'hCC;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;
    logic loadRes;
    logic setData;
    logic setDir;
    logic setCtrl;
    logic clrTo;
    logic setTo;
    logic capByte;
    logic nextByte;
    logic clrCnt;
    logic cntEn;
  } eppCmd_t;

  // decoded conditions from datapath to control
  typedef struct packed {
    logic [2:0] off;
    logic       high;
    logic       write;
    logic       wdat0;
    logic       gateOk;
    logic       dataSame;
    logic       ctrlSame;
    logic       dirChange;
    logic       lastByte;
    logic       cntExpired;
    logic       addrPort;
  } eppFlags_t;
endpackage

// File: rtl/epp_gate_datapath.sv
module epp_gate_datapath
  import epp_gate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  eppCmd_t           cmd,
  output eppFlags_t         flags,
  input  logic              hostHighWin,
  input  logic [2:0]        hostOff,
  input  logic              hostWrite,
  input  logic [1:0]        hostSize,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  input  logic [7:1]        statusIn,
  input  logic [7:0]        perDataIn,
  output logic [7:0]        perDataOut,
  output logic [7:0]        ctrlBus,
  output logic              ctrlStb,
  output logic              perDir,
  output logic              dirStb,
  output logic [7:0]        dataBus,
  output logic              dataStb
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [2:0]        reqOff;
  logic              reqHigh;
  logic              reqWrite;
  logic [1:0]        reqSize;
  logic [HOST_W-1:0] reqWdata;
  logic [7:0]        ctrlReg;
  logic [7:0]        dataReg;
  logic              dirReg;
  logic              toFlag;
  logic [HOST_W-1:0] resBuf;
  logic [IDX_W-1:0]  byteIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic [CNT_W-1:0]  waitCnt;
  logic [7:0]        newCtrl;
  logic [7:0]        gateBits;
  logic [HOST_W-1:0] onesWide;
  logic [HOST_W-1:0] resInit;

  assign newCtrl  = reqWdata[7:0] | CTRL_FIX;
  assign gateBits = ctrlReg & GATE_MASK;

  always_comb begin
    unique case (reqSize)
      2'd0:    onesWide = HOST_W'(8'hFF);
      2'd1:    onesWide = HOST_W'(16'hFFFF);
      default: onesWide = '1;
    endcase
  end

  always_comb begin
    if (reqOff == 3'd4)
      lastIdx = (reqSize == 2'd0) ? IDX_W'(0) :
                (reqSize == 2'd1) ? IDX_W'(1) : IDX_W'(HOST_B - 1);
    else
      lastIdx = '0;
  end

  always_comb begin
    resInit = HOST_W'(8'hFF);
    if (!reqHigh) begin
      unique case (reqOff)
        3'd0:    resInit = HOST_W'(perDataIn);
        3'd1:    resInit = HOST_W'({statusIn, toFlag});
        3'd2:    resInit = HOST_W'(ctrlReg);
        3'd4:    resInit = onesWide;
        default: resInit = HOST_W'(8'hFF);
      endcase
    end
  end

  always_comb begin
    flags.off        = reqOff;
    flags.high       = reqHigh;
    flags.write      = reqWrite;
    flags.wdat0      = reqWdata[0];
    flags.gateOk     = reqWrite ? (gateBits == GATE_WR) : (gateBits == GATE_RD);
    flags.dataSame   = (reqWdata[7:0] == dataReg);
    flags.ctrlSame   = (newCtrl == ctrlReg);
    flags.dirChange  = (newCtrl[5] != ctrlReg[5]);
    flags.lastByte   = (byteIdx == lastIdx);
    flags.cntExpired = (waitCnt == CNT_LAST);
    flags.addrPort   = (reqOff == 3'd3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOff   <= '0;
      reqHigh  <= 1'b0;
      reqWrite <= 1'b0;
      reqSize  <= '0;
      reqWdata <= '0;
      ctrlReg  <= CTRL_RST;
      dataReg  <= 8'hFF;
      dirReg   <= 1'b0;
      toFlag   <= 1'b0;
      resBuf   <= '0;
      byteIdx  <= '0;
      waitCnt  <= '0;
      dataStb  <= 1'b0;
      ctrlStb  <= 1'b0;
      dirStb   <= 1'b0;
    end else begin
      dataStb <= cmd.setData;
      ctrlStb <= cmd.setCtrl;
      dirStb  <= cmd.setDir;
      if (cmd.latch) begin
        reqOff   <= hostOff;
        reqHigh  <= hostHighWin;
        reqWrite <= hostWrite;
        reqSize  <= hostSize;
        reqWdata <= hostWdata;
      end
      if (cmd.loadRes) begin
        resBuf  <= resInit;
        byteIdx <= '0;
      end
      if (cmd.setData) dataReg <= reqWdata[7:0];
      if (cmd.setDir)  dirReg  <= newCtrl[5];
      if (cmd.setCtrl) ctrlReg <= newCtrl;
      if (cmd.setTo)      toFlag <= 1'b1;
      else if (cmd.clrTo) toFlag <= 1'b0;
      if (cmd.capByte)  resBuf[byteIdx*8 +: 8] <= perDataIn;
      if (cmd.nextByte) byteIdx <= byteIdx + 1'b1;
      if (cmd.clrCnt)     waitCnt <= '0;
      else if (cmd.cntEn) waitCnt <= waitCnt + 1'b1;
    end
  end

  assign perDataOut = reqWdata[byteIdx*8 +: 8];
  assign hostRdata  = resBuf;
  assign ctrlBus    = ctrlReg;
  assign dataBus    = dataReg;
  assign perDir     = dirReg;

  // R9
  dir_before_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirStb |=> ctrlStb);
  // R9
  ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus[7:6] == 2'b11);
  // R8
  data_pulse_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataStb |-> dataBus != $past(dataBus));
  // R6
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toFlag) |-> $past(cmd.clrTo));
endmodule

// File: rtl/epp_gate_fsm.sv
module epp_gate_fsm
  import epp_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostValid,
  input  logic      perWait,
  input  eppFlags_t flags,
  output eppCmd_t   cmd,
  output logic      hostReady,
  output logic      hostDone,
  output logic      perAddrStb,
  output logic      perDataStb,
  output logic      perWrite
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_CTRLSIG, ST_BYTE, ST_RELEASE, ST_DONE
  } eppState_e;

  eppState_e state, nextState;

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (hostValid) begin
          cmd.latch = 1'b1;
          nextState = ST_DECODE;
        end
      end
      ST_DECODE: begin
        cmd.loadRes = 1'b1;
        nextState   = ST_DONE;
        if (!flags.high) begin
          unique case (flags.off)
            3'd0: cmd.setData = flags.write && !flags.dataSame;
            3'd1: cmd.clrTo   = flags.write && flags.wdat0;
            3'd2: begin
              if (flags.write && !flags.ctrlSame) begin
                if (flags.dirChange) begin
                  cmd.setDir = 1'b1;
                  nextState  = ST_CTRLSIG;
                end else begin
                  cmd.setCtrl = 1'b1;
                end
              end
            end
            3'd3, 3'd4: begin
              if (flags.gateOk) begin
                cmd.clrCnt = 1'b1;
                nextState  = ST_BYTE;
              end
            end
            default: ;
          endcase
        end
      end
      ST_CTRLSIG: begin
        cmd.setCtrl = 1'b1;
        nextState   = ST_DONE;
      end
      ST_BYTE: begin
        cmd.cntEn = 1'b1;
        if (perWait) begin
          cmd.capByte = !flags.write;
          nextState   = ST_RELEASE;
        end else if (flags.cntExpired) begin
          cmd.setTo = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_RELEASE: begin
        if (flags.lastByte) begin
          nextState = ST_DONE;
        end else begin
          cmd.nextByte = 1'b1;
          cmd.clrCnt   = 1'b1;
          nextState    = ST_BYTE;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign hostReady  = (state == ST_IDLE);
  assign hostDone   = (state == ST_DONE);
  assign perAddrStb = (state == ST_BYTE) && flags.addrPort;
  assign perDataStb = (state == ST_BYTE) && !flags.addrPort;
  assign perWrite   = (state == ST_BYTE) && flags.write;

  // R12
  write_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    perWrite |-> (perAddrStb || perDataStb));
  // R7
  no_strobe_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !(perAddrStb || perDataStb));
endmodule

// File: rtl/epp_gate_ctrl.sv
module epp_gate_ctrl
  import epp_gate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic              hostHighWin,
  input  logic [2:0]        hostOff,
  input  logic              hostWrite,
  input  logic [1:0]        hostSize,
  input  logic [HOST_W-1:0] hostWdata,
  output logic              hostDone,
  output logic [HOST_W-1:0] hostRdata,
  input  logic [7:1]        statusIn,
  output logic              perAddrStb,
  output logic              perDataStb,
  output logic              perWrite,
  output logic [7:0]        perDataOut,
  input  logic [7:0]        perDataIn,
  input  logic              perWait,
  output logic [7:0]        ctrlBus,
  output logic              ctrlStb,
  output logic              perDir,
  output logic              dirStb,
  output logic [7:0]        dataBus,
  output logic              dataStb
);
  eppCmd_t   cmd;
  eppFlags_t flags;

  epp_gate_fsm u_fsm (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .perWait(perWait),
    .flags(flags), .cmd(cmd), .hostReady(hostReady), .hostDone(hostDone),
    .perAddrStb(perAddrStb), .perDataStb(perDataStb), .perWrite(perWrite)
  );

  epp_gate_datapath #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .flags(flags),
    .hostHighWin(hostHighWin), .hostOff(hostOff), .hostWrite(hostWrite),
    .hostSize(hostSize), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .statusIn(statusIn), .perDataIn(perDataIn), .perDataOut(perDataOut),
    .ctrlBus(ctrlBus), .ctrlStb(ctrlStb), .perDir(perDir), .dirStb(dirStb),
    .dataBus(dataBus), .dataStb(dataStb)
  );

  // R2 R3
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perAddrStb || perDataStb) |->
      (((ctrlBus & GATE_MASK) == GATE_WR) && perWrite) ||
      (((ctrlBus & GATE_MASK) == GATE_RD) && !perWrite));
  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({perAddrStb, perDataStb}));
endmodule

// File: tb/epp_gate_ctrl_bench.sv
module epp_gate_ctrl_bench;
  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0, hostHighWin = 1'b0, hostWrite = 1'b0;
  logic [2:0]  hostOff = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [7:1]  statusIn = 7'h53;
  logic        perWait = 1'b0;
  logic [7:0]  perDataIn;
  logic        hostReady, hostDone, perAddrStb, perDataStb, perWrite;
  logic        ctrlStb, perDir, dirStb, dataStb;
  logic [31:0] hostRdata;
  logic [7:0]  perDataOut, ctrlBus, dataBus;

  int checks = 0, errors = 0, cyc = 0;
  int stbCount = 0, dataStbCount = 0, ctrlStbCount = 0, dirCyc = -1, ctrlCyc = -1;
  int ackLimit = 0, ackUsed = 0, rdCnt = 0;
  logic [7:0]  rdBase = 8'h10;
  logic        rdByte = 1'b0, prevStb = 1'b0, curRead = 1'b0;
  logic [7:0]  wrLog[$];
  logic [31:0] expQ[$];
  string       tagQ[$];

  assign perDataIn = rdBase + 8'(rdCnt);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  epp_gate_ctrl #(.TIMEOUT_CYC(TO)) u_epp_gate_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
    .hostHighWin(hostHighWin), .hostOff(hostOff), .hostWrite(hostWrite),
    .hostSize(hostSize), .hostWdata(hostWdata), .hostDone(hostDone),
    .hostRdata(hostRdata), .statusIn(statusIn), .perAddrStb(perAddrStb),
    .perDataStb(perDataStb), .perWrite(perWrite), .perDataOut(perDataOut),
    .perDataIn(perDataIn), .perWait(perWait), .ctrlBus(ctrlBus),
    .ctrlStb(ctrlStb), .perDir(perDir), .dirStb(dirStb), .dataBus(dataBus),
    .dataStb(dataStb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peripheral model and event counters
  always @(negedge clk) begin
    if (rstN) begin
      if ((perAddrStb || perDataStb) && !prevStb) stbCount++;
      prevStb = perAddrStb || perDataStb;
      if (dataStb) dataStbCount++;
      if (ctrlStb) begin ctrlStbCount++; ctrlCyc = cyc; end
      if (dirStb) dirCyc = cyc;
      if ((perAddrStb || perDataStb) && !perWait) begin
        if (ackUsed < ackLimit) begin
          perWait <= 1'b1;
          ackUsed <= ackUsed + 1;
          rdByte  <= !perWrite;
          if (perWrite) wrLog.push_back(perDataOut);
        end
      end else if (!(perAddrStb || perDataStb) && perWait) begin
        perWait <= 1'b0;
        if (rdByte) rdCnt <= rdCnt + 1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && hostDone && curRead) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read result actual=%h expected=none", hostRdata);
      end else begin
        check(tagQ.pop_front(), hostRdata, expQ.pop_front());
      end
    end
  end

  task automatic access(input logic high, input logic [2:0] off, input logic wr,
                        input logic [1:0] size, input logic [31:0] wd,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    hostHighWin = high; hostOff = off; hostWrite = wr; hostSize = size;
    hostWdata = wd; curRead = !wr;
    if (!wr) begin expQ.push_back(exp); tagQ.push_back(tag); end
    hostValid = 1'b1;
    @(negedge clk);
    hostValid = 1'b0;
    while (!hostDone) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrlBus", ctrlBus, 8'hCC);
    check("R1 dataBus", dataBus, 8'hFF);
    check("R1 perDir", perDir, 0);
    check("R1 strobes", {perAddrStb, perDataStb, dataStb, ctrlStb, dirStb}, 0);
    access(0, 3'd2, 0, 0, 0, 32'hCC, "R1 control read");
    access(0, 3'd1, 0, 0, 0, 32'hA6, "R1 R5 status flag clear");

    // R3 gating fails in reset control state
    ackLimit = 100;
    access(0, 3'd4, 0, 2'd0, 0, 32'h0000_00FF, "R3 byte ones");
    access(0, 3'd4, 0, 2'd1, 0, 32'h0000_FFFF, "R3 half ones");
    access(0, 3'd4, 0, 2'd2, 0, 32'hFFFF_FFFF, "R3 word ones");
    access(0, 3'd3, 0, 2'd0, 0, 32'h0000_00FF, "R3 addr ones");
    // R2 write dropped
    access(0, 3'd4, 1, 2'd0, 32'h77, 0, "");
    check("R2 R3 no strobe when gated", stbCount, 0);

    // R8 data register
    access(0, 3'd0, 1, 0, 32'h5A, 0, "");
    @(negedge clk);
    check("R8 dataBus", dataBus, 8'h5A);
    check("R8 pulse", dataStbCount, 1);
    access(0, 3'd0, 1, 0, 32'h5A, 0, "");
    @(negedge clk);
    check("R8 same value no pulse", dataStbCount, 1);

    // R9 control write, no direction change
    access(0, 3'd2, 1, 0, 32'h04, 0, "");
    @(negedge clk);
    check("R9 ctrl pulse", ctrlStbCount, 1);
    check("R9 ctrlBus or C0", ctrlBus, 8'hC4);
    check("R9 dir unchanged", perDir, 0);
    access(0, 3'd2, 1, 0, 32'h04, 0, "");
    @(negedge clk);
    check("R9 same value no pulse", ctrlStbCount, 1);

    // R4 R2 write cycles
    access(0, 3'd3, 1, 2'd2, 32'h1122_3344, 0, "");
    access(0, 3'd4, 1, 2'd2, 32'hA1B2_C3D4, 0, "");
    access(0, 3'd4, 1, 2'd1, 32'h0000_1234, 0, "");
    check("R4 write byte count", wrLog.size(), 7);
    if (wrLog.size() == 7) begin
      check("R4 addr byte", wrLog[0], 8'h44);
      check("R4 data lane order", {wrLog[4], wrLog[3], wrLog[2], wrLog[1]}, 32'hA1B2_C3D4);
      check("R4 half order", {wrLog[6], wrLog[5]}, 16'h1234);
    end
    check("R2 strobes issued", stbCount, 7);

    // R9 direction change
    access(0, 3'd2, 1, 0, 32'h24, 0, "");
    @(negedge clk);
    check("R9 perDir new", perDir, 1);
    check("R9 dir one cycle before ctrl", ctrlCyc - dirCyc, 1);
    check("R9 ctrlBus", ctrlBus, 8'hE4);

    // R3 R4 read cycles
    access(0, 3'd4, 0, 2'd2, 0, 32'h1312_1110, "R4 R3 word read");
    access(0, 3'd3, 0, 2'd2, 0, 32'h0000_0014, "R4 addr read one byte");
    s0 = stbCount;
    access(0, 3'd4, 1, 2'd0, 32'h99, 0, "");
    check("R2 write gated in read mode", stbCount, s0);

    // R5 R7 timeout mid access
    ackLimit = ackUsed + 1;
    s0 = stbCount;
    access(0, 3'd4, 0, 2'd2, 0, 32'hFFFF_FF15, "R7 partial read");
    repeat (4) @(negedge clk);
    check("R7 strobes stop", stbCount - s0, 2);
    access(0, 3'd1, 0, 0, 0, 32'hA7, "R5 status flag set");

    // R6 clear
    access(0, 3'd1, 1, 0, 32'hFE, 0, "");
    access(0, 3'd1, 0, 0, 0, 32'hA7, "R6 bit0 zero keeps flag");
    access(0, 3'd1, 1, 0, 32'h01, 0, "");
    access(0, 3'd1, 0, 0, 0, 32'hA6, "R6 bit0 one clears");

    // R10 upper window
    ackLimit = ackUsed + 100;
    s0 = ctrlStbCount;
    access(1, 3'd2, 1, 0, 32'h00, 0, "");
    access(1, 3'd0, 1, 0, 32'h33, 0, "");
    access(1, 3'd4, 0, 2'd2, 0, 32'hFF, "R10 high read");
    @(negedge clk);
    check("R10 ctrl untouched", ctrlBus, 8'hE4);
    check("R10 data untouched", dataBus, 8'h5A);
    check("R10 no ctrl pulse", ctrlStbCount, s0);

    // R11 plain reads
    access(0, 3'd0, 0, 0, 0, 32'h16, "R11 data pins read");
    access(0, 3'd2, 0, 0, 0, 32'hE4, "R11 control read");
    access(0, 3'd6, 0, 0, 0, 32'hFF, "R11 unused offset");
    repeat (2) @(negedge clk);
    check("scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule